// File: doc/BRIEF.md
# Eight-Function Gated ALU

A purely combinational 16-bit arithmetic and logic unit. Two operands, a carry input and a 3-bit function code go in. A 16-bit result and a 4-bit status word come out. All eight function units work on the operands at the same time: add, shift right, shift left, invert, AND, OR, XOR and compare. A 3-to-8 decoder turns the function code into one-hot select lines. Each select line gates one unit's result and, where it has one, that unit's carry. The gated values are then ORed together, so no multiplexer tree sits in the datapath.

The magnitude comparator runs for every function code. A control unit can therefore read the greater and equal status bits after any operation and always sees values for the current operands. The compare code puts no value on the result. It also masks the zero detector, so the zero status bit stays clear. The block holds no state. A surrounding datapath latches the result and status where it needs them.

Top module: `gated_alu`

## Requirements
- R1: Function code 000 is ADD: the result is the low 16 bits of a + b + carry_in, and status bit 0 is the carry out of bit 15.
- R2: Function code 001 is SHR: the result is a shifted right by one with a 0 entering bit 15, and status bit 0 equals a[0].
- R3: Function code 010 is SHL: the result is a shifted left by one with a 0 entering bit 0, and status bit 0 equals a[15].
- R4: Function codes 011, 100, 101 and 110 give ~a, a & b, a | b and a ^ b in that order.
- R5: Function code 111 is CMP: the result is all zeros and status bit 3 (zero) is 0.
- R6: The status word carries carry in bit 0, a-greater in bit 1, a-equals-b in bit 2 and result-is-zero in bit 3.
- R7: For every function code, status bit 1 is 1 exactly when a > b unsigned, and status bit 2 is 1 exactly when a == b.
- R8: For every function code except 111, status bit 3 is 1 exactly when the 16-bit result is zero.
- R9: Status bit 0 is 0 for every function code other than 000, 001 and 010, whatever the operands and carry_in.
- R10: The decoded select lines are one-hot, so exactly one unit reaches the result for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; the only source for the shifts and invert |
| b_i | input | 16 | Second operand |
| carry_in_i | input | 1 | Carry added into the ADD function |
| op_i | input | 3 | Function code |
| result_o | output | 16 | Result of the selected function |
| flags_o | output | 4 | Status word: {zero, equal, a-greater, carry} |

## Verification
The bench goes after the carry paths. These are ADD overflow with and without carry-in, and a shift whose shifted-out bit is 1 and then 0. A design that routed a carry without gating it by its select line would show a stray carry on logic functions or on the other shift. The compare code with equal operands is the trap for the zero detector. An ungated detector would report zero, because the result bus is all zeros. Equal, greater and smaller operand pairs under non-compare codes catch a comparator that only updates for CMP. A result of exactly zero from AND, and a sum that wraps to zero, check the zero bit from both sides.

// File: rtl/gated_alu_pkg.sv
package gated_alu_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned OPW = 3;
  localparam int unsigned NOPS = 1 << OPW;

  typedef enum logic [OPW-1:0] {
    FN_ADD = 3'd0,
    FN_SHR = 3'd1,
    FN_SHL = 3'd2,
    FN_INV = 3'd3,
    FN_AND = 3'd4,
    FN_OR  = 3'd5,
    FN_XOR = 3'd6,
    FN_CMP = 3'd7
  } alu_fn_e;

  // status word bit positions
  localparam int unsigned ST_CARRY = 0;
  localparam int unsigned ST_GT    = 1;
  localparam int unsigned ST_EQ    = 2;
  localparam int unsigned ST_ZERO  = 3;
  localparam int unsigned STW      = 4;

  // sum with carry out at the top bit
  function automatic logic [DW:0] add_with_carry(input logic [DW-1:0] x,
                                                 input logic [DW-1:0] y,
                                                 input logic cin);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  endfunction

  // {shifted_out, shifted}
  function automatic logic [DW:0] shift_right_one(input logic [DW-1:0] x);
    return {x[0], 1'b0, x[DW-1:1]};
  endfunction

  function automatic logic [DW:0] shift_left_one(input logic [DW-1:0] x);
    return {x[DW-1], x[DW-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/fn_decoder.sv
module fn_decoder
  import gated_alu_pkg::*;
#(
  parameter int unsigned SELW = OPW,
  localparam int unsigned LINES = 1 << SELW
) (
  input  logic [SELW-1:0]  code_i,
  output logic [LINES-1:0] line_o
);
  genvar k;
  generate
    for (k = 0; k < LINES; k++) begin : g_line
      assign line_o[k] = (code_i == SELW'(k));
    end
  endgenerate
endmodule

// File: rtl/unit_bank.sv
module unit_bank
  import gated_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            cin_i,
  input  logic [NOPS-1:0] line_i,
  output logic [W-1:0]    result_o,
  output logic            carry_o
);
  logic [W:0] sum_w, shr_w, shl_w;
  logic [W-1:0] raw   [NOPS];
  logic [NOPS-1:0] craw;
  logic [W-1:0] gated [NOPS];
  logic [NOPS-1:0] cgated;

  assign sum_w = add_with_carry(a_i, b_i, cin_i);
  assign shr_w = shift_right_one(a_i);
  assign shl_w = shift_left_one(a_i);

  always_comb begin
    raw[FN_ADD] = sum_w[W-1:0];
    raw[FN_SHR] = shr_w[W-1:0];
    raw[FN_SHL] = shl_w[W-1:0];
    raw[FN_INV] = ~a_i;
    raw[FN_AND] = a_i & b_i;
    raw[FN_OR]  = a_i | b_i;
    raw[FN_XOR] = a_i ^ b_i;
    raw[FN_CMP] = '0;               // compare puts nothing on the result
    craw         = '0;
    craw[FN_ADD] = sum_w[W];
    craw[FN_SHR] = shr_w[W];
    craw[FN_SHL] = shl_w[W];
  end

  genvar k;
  generate
    for (k = 0; k < NOPS; k++) begin : g_gate
      assign gated[k]  = raw[k] & {W{line_i[k]}};
      assign cgated[k] = craw[k] & line_i[k];
    end
  endgenerate

  always_comb begin
    result_o = '0;
    for (int i = 0; i < NOPS; i++) result_o = result_o | gated[i];
  end
  assign carry_o = |cgated;
endmodule

// File: rtl/mag_compare.sv
module mag_compare
  import gated_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         eq_o
);
  assign gt_o = a_i > b_i;
  assign eq_o = a_i == b_i;
endmodule

// File: rtl/zero_detect.sv
module zero_detect
  import gated_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] value_i,
  input  logic         mask_i,
  output logic         zero_o
);
  logic [W-1:0] probe_w;
  // masking drives all ones, so the detector sees non-zero
  assign probe_w = value_i | {W{mask_i}};
  assign zero_o  = ~|probe_w;
endmodule

// File: rtl/gated_alu.sv
module gated_alu
  import gated_alu_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           carry_in_i,
  input  logic [OPW-1:0] op_i,
  output logic [DW-1:0]  result_o,
  output logic [STW-1:0] flags_o
);
  logic [NOPS-1:0] sel_lines;
  logic            carry_w, gt_w, eq_w, zero_w;
  logic [DW-1:0]   result_w;

  fn_decoder #(.SELW(OPW)) u_dec (.code_i(op_i), .line_o(sel_lines));

  unit_bank #(.W(DW)) u_units (
    .a_i(a_i), .b_i(b_i), .cin_i(carry_in_i), .line_i(sel_lines),
    .result_o(result_w), .carry_o(carry_w)
  );

  mag_compare #(.W(DW)) u_cmp (.a_i(a_i), .b_i(b_i), .gt_o(gt_w), .eq_o(eq_w));

  zero_detect #(.W(DW)) u_zero (
    .value_i(result_w), .mask_i(sel_lines[FN_CMP]), .zero_o(zero_w)
  );

  assign result_o = result_w;
  always_comb begin
    flags_o           = '0;
    flags_o[ST_CARRY] = carry_w;
    flags_o[ST_GT]    = gt_w;
    flags_o[ST_EQ]    = eq_w;
    flags_o[ST_ZERO]  = zero_w;
  end

  always_comb begin
    a_r10_onehot_select: assert ($countones(sel_lines) == 1);
    a_r5_cmp_clears: assert (!sel_lines[FN_CMP] || (result_w == '0 && !zero_w));
    a_r9_no_stray_carry: assert (sel_lines[FN_ADD] || sel_lines[FN_SHR] ||
                                 sel_lines[FN_SHL] || !carry_w);
    a_r7_gt_eq_exclusive: assert (!(gt_w && eq_w));
    a_r8_zero_tracks: assert (sel_lines[FN_CMP] || (zero_w == (result_w == '0)));
  end
endmodule

// File: tb/gated_alu_bench.sv
module gated_alu_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a, b, res;
  logic        cin;
  logic [2:0]  op;
  logic [3:0]  flg;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  gated_alu u_gated_alu (.a_i(a), .b_i(b), .carry_in_i(cin), .op_i(op),
                         .result_o(res), .flags_o(flg));

  // independent reference: {zero, eq, gt, carry} and result
  task automatic model(input logic [15:0] x, y, input logic ci, input logic [2:0] f,
                       output logic [15:0] r, output logic [3:0] s);
    logic c;
    int unsigned t;
    c = 0;
    case (f)
      3'd0: begin t = int'(x) + int'(y) + int'(ci); r = t[15:0]; c = t[16]; end
      3'd1: begin r = x / 2; c = x[0]; end
      3'd2: begin r = 16'(x * 2); c = x[15]; end
      3'd3: r = 16'hFFFF - x;
      3'd4: r = x & y;
      3'd5: r = x | y;
      3'd6: r = x ^ y;
      default: r = 0;
    endcase
    s = {(f != 3'd7) && (r == 0), x == y, x > y, c};
  endtask

  task automatic apply(input logic [15:0] x, y, input logic ci, input logic [2:0] f,
                       input string tag);
    logic [15:0] er; logic [3:0] ef;
    @(negedge clk);
    a = x; b = y; cin = ci; op = f;
    #1;
    model(x, y, ci, f, er, ef);
    n_chk++;
    if (res !== er || flg !== ef) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0b: result %h flags %b, expected %h flags %b",
               tag, f, x, y, ci, res, flg, er, ef);
    end
  endtask

  task automatic t_idle; // quiet inputs: R6 layout, ADD zero sum
    apply(16'h0, 16'h0, 1'b0, 3'd0, "R6 R8 idle");
  endtask
  task automatic t_add;
    apply(16'h1234, 16'h0111, 1'b0, 3'd0, "R1 plain");
    apply(16'hFFFF, 16'h0001, 1'b0, 3'd0, "R1 R8 wrap to zero");
    apply(16'h8000, 16'h8000, 1'b1, 3'd0, "R1 overflow with carry_in");
    apply(16'h0010, 16'h0020, 1'b1, 3'd0, "R1 carry_in adds");
  endtask
  task automatic t_shift;
    apply(16'h8001, 16'h0000, 1'b1, 3'd1, "R2 shr out 1");
    apply(16'h8002, 16'h0000, 1'b0, 3'd1, "R2 shr out 0");
    apply(16'h8001, 16'h0000, 1'b0, 3'd2, "R3 shl out 1");
    apply(16'h4001, 16'h0000, 1'b1, 3'd2, "R3 shl out 0");
  endtask
  task automatic t_logic;
    apply(16'hFFFF, 16'hFFFF, 1'b1, 3'd3, "R4 R9 not");
    apply(16'hF0F0, 16'h0F0F, 1'b1, 3'd4, "R4 R8 and zero");
    apply(16'hF0F0, 16'h0F0F, 1'b1, 3'd5, "R4 R9 or");
    apply(16'hAAAA, 16'hAAAA, 1'b1, 3'd6, "R4 R7 xor equal");
  endtask
  task automatic t_cmp;
    apply(16'h0000, 16'h0000, 1'b1, 3'd7, "R5 equal zeros");
    apply(16'h9000, 16'h7FFF, 1'b0, 3'd7, "R5 R7 greater unsigned");
    apply(16'h0001, 16'hFFFF, 1'b0, 3'd7, "R5 R7 smaller");
  endtask
  task automatic t_flags_all_ops; // R7 R10 every code
    for (int f = 0; f < 8; f++) begin
      apply(16'h5000, 16'h4FFF, 1'b1, f[2:0], "R7 R10 gt per code");
      apply(16'h3333, 16'h3333, 1'b0, f[2:0], "R7 R10 eq per code");
    end
  endtask
  task automatic t_random;
    for (int i = 0; i < 400; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), 3'($urandom), "R1 R4 R9 random");
  endtask

  initial begin
    a = 0; b = 0; cin = 0; op = 0;
    t_idle(); t_add(); t_shift(); t_logic(); t_cmp(); t_flags_all_ops(); t_random();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run stuck, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule